// File: doc/BRIEF.md
# One-Shot Interval Timer

This block measures a single programmed interval and then signals its end. Software chooses a terminal count and a tick rate, then sets the run bit. The counter advances once per selected tick. On the tick that finds the counter equal to the terminal count, the block does four things:

- it sets a sticky timeout flag;
- it drops the run bit;
- it returns the counter to zero;
- it keeps the terminal count and tick rate, so one more write to the run bit repeats the same interval.

The block is clocked by a reference clock of nominally 32.768 kHz. A cascaded prescaler divides this clock to produce the slower ticks. A level interrupt is raised while the timeout flag and the interrupt mask bit are both set. The flag is cleared by writing a one to it.

All registers are reached through a flat write strobe with an address and write data. Reads are combinational from the address.

Top module: `one_shot_timer`

## Requirements
- R1: After reset every register (terminal count, time base, run bit, interrupt mask, timeout flag, counter) reads zero and `irq` is low.
- R2: The register map is as follows:
  - address 0: terminal count, 8 bits;
  - address 1: time base, bits [1:0], upper bits read zero;
  - address 2: run bit, bit 0;
  - address 3: interrupt mask, bit 0;
  - address 4: timeout flag, bit 0;
  - address 5: counter, read only.
  Written values read back on the next cycle.
- R3: The time base code selects the tick period. The periods in reference cycles are:
  - 0: one cycle;
  - 1: FAST_DIV cycles;
  - 2: FAST_DIV·SEC_DIV cycles;
  - 3: FAST_DIV·SEC_DIV·MIN_DIV cycles.
  With the defaults (32, 1024, 60) these give 32.768 kHz, 1024 Hz, 1 Hz and one minute. The prescaler phase restarts on every run-bit write, so the first tick comes one full period after that write.
- R4: While running, the counter rises by one per tick. The tick that finds the counter equal to the terminal count T is the timeout, which comes (T+1)·period cycles after the run write. A terminal count of 0 therefore times out on the first tick.
- R5: At timeout the timeout flag goes to 1, the run bit goes to 0, and the counter goes to 0. The terminal count and time base are kept, and a new run write repeats the same interval.
- R6: The timeout flag holds until software writes address 4 with bit 0 = 1. Writing bit 0 = 0 leaves the flag unchanged.
- R7: `irq` is high exactly while both the timeout flag and the interrupt mask bit are 1.
- R8: Writing 0 to the run bit while counting stops the timer, zeroes the counter and does not set the timeout flag.
- R9: Writing 1 to the run bit while counting restarts the interval from zero. If a run-bit write and a timeout fall in the same cycle, the write takes effect and the timeout is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Read data for `addr` |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the timer with FAST_DIV=4, SEC_DIV=3 and MIN_DIV=2. This makes the four tick periods 1, 4, 12 and 24 cycles.

With these values, every time base, including the minute rate and a terminal count of 255, finishes in a few thousand cycles. Each timeout can be checked at its exact cycle, one cycle early and on the cycle it lands. It also becomes cheap to test a stop or restart write in the middle of an interval.

// File: rtl/one_shot_timer_pkg.sv
package one_shot_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_TERM = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_BASE = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RUN  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd5;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;      // counting enabled
    logic restart;  // run-bit write this cycle: clear counter and prescaler
  } dpStrobe_t;
endpackage

// File: rtl/one_shot_timer_dpath.sv
module one_shot_timer_dpath
  import one_shot_timer_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int FAST_DIV = 32,
  parameter int SEC_DIV  = 1024,
  parameter int MIN_DIV  = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobe,
  input  logic [1:0]       timeBase,
  input  logic [CNT_W-1:0] termVal,
  output logic [CNT_W-1:0] countVal,
  output logic             hit
);
  localparam int STAGES = 3;

  function automatic int stageDiv(int idx);
    case (idx)
      0:       return FAST_DIV;
      1:       return SEC_DIV;
      default: return MIN_DIV;
    endcase
  endfunction

  // tickVec[k] is the tick for time base code k
  logic [STAGES:0] tickVec;
  logic            clearAll;
  logic            tickSel;

  assign tickVec[0] = strobe.run;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      localparam int DIV = stageDiv(g);
      localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;
      logic [PW-1:0] phase;
      logic          wrap;
      assign wrap = (phase == PW'(DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || clearAll) phase <= '0;
        else if (tickVec[g])   phase <= wrap ? '0 : phase + PW'(1);
      end
      assign tickVec[g+1] = tickVec[g] & wrap;
    end
  endgenerate

  assign tickSel  = tickVec[timeBase];
  assign hit      = tickSel && (countVal == termVal) && !strobe.restart;
  assign clearAll = strobe.restart | hit;

  always_ff @(posedge clk) begin
    if (!rst_n || clearAll) countVal <= '0;
    else if (tickSel)       countVal <= countVal + CNT_W'(1);
  end

  // R4
  // count_step_chk
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clearAll |=> (countVal == $past(countVal) || countVal == $past(countVal) + CNT_W'(1)));

  // R5
  // count_clear_chk
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clearAll |=> (countVal == '0));

  // R8
  // idle_hold_chk
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.run && !strobe.restart) |=> $stable(countVal));
endmodule

// File: rtl/one_shot_timer_ctrl.sv
module one_shot_timer_ctrl
  import one_shot_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hit,
  input  logic [CNT_W-1:0]  countVal,
  output dpStrobe_t         strobe,
  output logic [1:0]        timeBase,
  output logic [CNT_W-1:0]  termVal,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  logic runReg, maskReg, flagReg;
  logic runWr, flagClr;

  assign runWr   = wrEn && (addr == ADDR_RUN);
  assign flagClr = wrEn && (addr == ADDR_FLAG) && wrData[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      termVal  <= '0;
      timeBase <= '0;
      maskReg  <= 1'b0;
    end else if (wrEn) begin
      if (addr == ADDR_TERM) termVal  <= wrData[CNT_W-1:0];
      if (addr == ADDR_BASE) timeBase <= wrData[1:0];
      if (addr == ADDR_MASK) maskReg  <= wrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     runReg <= 1'b0;
    else if (runWr) runReg <= wrData[0];
    else if (hit)   runReg <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flagReg <= 1'b0;
    else if (hit)     flagReg <= 1'b1;
    else if (flagClr) flagReg <= 1'b0;
  end

  assign strobe.run     = runReg;
  assign strobe.restart = runWr;
  assign irq            = flagReg & maskReg;

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_TERM: rdData[CNT_W-1:0] = termVal;
      ADDR_BASE: rdData[1:0]       = timeBase;
      ADDR_RUN:  rdData[0]         = runReg;
      ADDR_MASK: rdData[0]         = maskReg;
      ADDR_FLAG: rdData[0]         = flagReg;
      ADDR_CNT:  rdData[CNT_W-1:0] = countVal;
      default:   rdData            = '0;
    endcase
  end

  // R5
  // timeout_selfclear_chk
  timeout_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (!runReg && flagReg));

  // R6
  // flag_sticky_chk
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagReg && !flagClr) |=> flagReg);

  // R4
  // hit_when_running_chk
  hit_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> runReg);
endmodule

// File: rtl/one_shot_timer.sv
module one_shot_timer
  import one_shot_timer_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int FAST_DIV = 32,
  parameter int SEC_DIV  = 1024,
  parameter int MIN_DIV  = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  dpStrobe_t        strobe;
  logic [1:0]       timeBase;
  logic [CNT_W-1:0] termVal;
  logic [CNT_W-1:0] countVal;
  logic             hit;

  one_shot_timer_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .hit(hit), .countVal(countVal), .strobe(strobe), .timeBase(timeBase),
    .termVal(termVal), .rdData(rdData), .irq(irq)
  );

  one_shot_timer_dpath #(
    .CNT_W(CNT_W), .FAST_DIV(FAST_DIV), .SEC_DIV(SEC_DIV), .MIN_DIV(MIN_DIV)
  ) uDpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .timeBase(timeBase),
    .termVal(termVal), .countVal(countVal), .hit(hit)
  );
endmodule

// File: tb/tb_one_shot_timer.sv
module tb_one_shot_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  one_shot_timer #(.CNT_W(8), .FAST_DIV(4), .SEC_DIV(3), .MIN_DIV(2)) dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  base;
    logic [7:0]  term;
    logic [31:0] cycles;
  } vec_t;

  // Periods with bench divisors: base0=1, base1=4, base2=12, base3=24
  localparam vec_t VECS [7] = '{
    '{2'd0, 8'd0,   32'd1},
    '{2'd0, 8'd5,   32'd6},
    '{2'd1, 8'd2,   32'd12},
    '{2'd2, 8'd1,   32'd24},
    '{2'd3, 8'd0,   32'd24},
    '{2'd3, 8'd2,   32'd72},
    '{2'd1, 8'd255, 32'd1024}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int v;
    waitCyc(3);
    rst_n = 1'b1;
    waitCyc(1);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reset reg", v, 0);
    end
    chk("R1 irq", irq, 0);

    // R2 register readback
    wr(3'd0, 8'hA5); rd(3'd0, v); chk("R2 term", v, 8'hA5);
    wr(3'd1, 8'hFF); rd(3'd1, v); chk("R2 base", v, 3);
    wr(3'd3, 8'h01); rd(3'd3, v); chk("R2 mask", v, 1);
    wr(3'd3, 8'h00);

    // R3 R4 R5 vector walk: timeout exactly at (T+1)*period cycles
    for (int i = 0; i < 7; i++) begin
      wr(3'd0, VECS[i].term);
      wr(3'd1, {6'd0, VECS[i].base});
      wr(3'd2, 8'h01);
      waitCyc(int'(VECS[i].cycles) - 1);
      rd(3'd4, v); chk("R3 flag before timeout", v, 0);
      rd(3'd2, v); chk("R4 running before timeout", v, 1);
      waitCyc(1);
      rd(3'd4, v); chk("R3 flag at timeout", v, 1);
      rd(3'd2, v); chk("R5 run self-clear", v, 0);
      rd(3'd5, v); chk("R5 counter zero", v, 0);
      rd(3'd0, v); chk("R5 term kept", v, VECS[i].term);
      wr(3'd4, 8'h01);
    end

    // R4 counter advances per tick
    wr(3'd0, 8'd10); wr(3'd1, 8'd0); wr(3'd2, 8'h01);
    waitCyc(3);
    rd(3'd5, v); chk("R4 count mid-run", v, 3);

    // R9 restart mid-run
    wr(3'd2, 8'h01);
    rd(3'd5, v); chk("R9 count after restart", v, 0);
    waitCyc(10);
    rd(3'd4, v); chk("R9 no early timeout", v, 0);
    waitCyc(1);
    rd(3'd4, v); chk("R9 timeout after restart", v, 1);
    wr(3'd4, 8'h01);

    // R8 stop mid-run
    wr(3'd2, 8'h01);
    waitCyc(4);
    wr(3'd2, 8'h00);
    rd(3'd5, v); chk("R8 count zeroed", v, 0);
    rd(3'd2, v); chk("R8 run cleared", v, 0);
    waitCyc(20);
    rd(3'd4, v); chk("R8 no timeout", v, 0);
    rd(3'd5, v); chk("R8 count held", v, 0);

    // R6 R7 flag and interrupt
    wr(3'd0, 8'd0); wr(3'd2, 8'h01);
    waitCyc(2);
    chk("R7 irq masked", irq, 0);
    wr(3'd3, 8'h01);
    chk("R7 irq raised", irq, 1);
    wr(3'd4, 8'h00);
    rd(3'd4, v); chk("R6 write 0 ignored", v, 1);
    chk("R7 irq still high", irq, 1);
    wr(3'd3, 8'h00);
    chk("R7 irq mask off", irq, 0);
    wr(3'd3, 8'h01);
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk("R6 w1c clears", v, 0);
    chk("R7 irq after clear", irq, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule